// File: doc/BRIEF.md
# CPU Bus Freeze Controller

This block halts an 8-bit home-computer CPU so that an expansion device can own the system bus. It watches the phase clock, the bus-available line from the video chip and the CPU read/write strobe. When software raises a freeze request, the block drives a DMA request towards the CPU. It picks the moment for that request with three strategies, tried from safest to least safe.

The safest strategy latches onto a video bad line and keeps it going. The second waits for the three back-to-back writes that the CPU makes when it enters an interrupt. The last resort raises DMA at the next bus-cycle boundary and accepts that a write in flight may be lost. Each fallback is gated by its own timeout, counted in full bus cycles. In double-speed mode the CPU also owns the video half of each cycle, so writes are counted per half-cycle. A forced stall is then placed on any half-cycle boundary, never inside a half.

Once DMA is up and the bus has stayed idle for one full cycle, the block reports the CPU as frozen and shows which strategy worked. Dropping the request lets the CPU run again on the next phase-clock edge. The clock mode is an input; the block does not work it out.

Top module: `freeze_ctrl`

## Requirements
- R1: While reset is low, and on the first cycles after it, `dma_req`=0, `frozen`=0 and `method`=0.
- R2: While the block waits for a bad line, a half-cycle that ends with `ba`=0 raises `dma_req` at that boundary. `dma_req` stays high, with `frozen`=0, until a half-cycle ends with `ba`=1. The strategy code then becomes 1.
- R3: The block waits for a bad line for `tmo_badline` full cycles. Each full cycle ends on a falling `phi2` edge. It then waits for a write streak.
- R4: In normal mode only the CPU half-cycles count for the write streak. These are the halves with `phi2` high. Three consecutive CPU halves ending with `rw_n`=0 raise `dma_req` at the boundary that closes the third, and set strategy code 2. Writes in the video half (`phi2` low) neither add to nor break the streak.
- R5: In fast mode (`fast_mode`=1) every half-cycle counts. Three consecutive half-cycles ending with `rw_n`=0 raise `dma_req` at the boundary that closes the third, and set strategy code 2. A read between them restarts the count.
- R6: After a further `tmo_writes` full cycles without a streak, DMA is forced and the strategy code becomes 3. In normal mode the force lands on the next falling `phi2` edge. In fast mode it lands on the next `phi2` edge of either direction. So with only reads on the bus, `dma_req` first rises at half-cycle 2(B+W)+1 in normal mode and 2(B+W) in fast mode. B and W are the effective timeouts, and half-cycles are counted from the request, video half first.
- R7: `dma_req` changes only at a half-cycle boundary, never in the middle of a half-cycle.
- R8: `frozen` rises when `dma_req` is high and two consecutive half-cycles (one full cycle) have ended with `rw_n`=1. `frozen`=1 implies `dma_req`=1.
- R9: Lowering `freeze_req` while `dma_req` is high drops both `dma_req` and `frozen` at the next half-cycle boundary. Lowering it while the block is still waiting returns the block to idle, and no DMA follows.
- R10: The strategy code (0 none, 1 bad line, 2 write streak, 3 forced) is cleared to 0 when a request is accepted. It is held from the moment DMA is taken, through release, until the next request.
- R11: A timeout value of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `phi2` |
| rst_n | input | 1 | Active-low synchronous reset |
| phi2 | input | 1 | Bus phase clock: high = CPU half, low = video half |
| ba | input | 1 | Bus-available from the video chip, low during a bad line |
| rw_n | input | 1 | CPU strobe, 1 = read, 0 = write |
| freeze_req | input | 1 | Hold high to freeze the CPU, drop to release it |
| fast_mode | input | 1 | 1 when the CPU runs at double speed |
| tmo_badline | input | TMR_W | Full cycles to wait for a bad line |
| tmo_writes | input | TMR_W | Full cycles to wait for a write streak |
| dma_req | output | 1 | DMA request to the CPU, active high |
| frozen | output | 1 | CPU held and bus idle |
| method | output | 2 | Strategy that took the bus (0 none, 1 bad line, 2 writes, 3 forced) |

## Verification
The case hardest to reach from the ports is the exact boundary at which the forced fallback takes the bus. It depends on two chained timeouts, on the zero-means-one rule and on the clock mode. The bench sweeps every pair of small timeouts in both modes with a read-only bus. It computes the expected first DMA half-cycle and first frozen half-cycle with a formula. The write-streak paths are reached with near-miss patterns first. In normal mode these are video-half writes; in fast mode they are runs broken by a read. Each path then ends with a clean streak. This shows that the mode decides which halves count.

// File: rtl/frz_pkg.sv
package frz_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT_BAD,
    S_HOLD_BAD,
    S_WAIT_WR,
    S_FORCE,
    S_SETTLE,
    S_FROZEN
  } frz_state_t;

  typedef enum logic [1:0] {
    M_NONE    = 2'd0,
    M_BADLINE = 2'd1,
    M_STREAK  = 2'd2,
    M_FORCED  = 2'd3
  } frz_method_t;

  typedef struct packed {
    logic phi;
    logic rd;
    logic ba;
  } bus_smp_t;

  // Next write-streak count: saturates at 3, a read restarts it.
  function automatic logic [1:0] streak_next(logic [1:0] cur, logic is_wr);
    if (!is_wr) return 2'd0;
    return (cur == 2'd3) ? 2'd3 : cur + 2'd1;
  endfunction

  // True once 'done' full cycles have elapsed; a limit of 0 counts as 1.
  function automatic logic limit_reached(int unsigned done, int unsigned limit);
    int unsigned eff;
    eff = (limit == 0) ? 1 : limit;
    return done >= eff;
  endfunction

endpackage

// File: rtl/phase_sampler.sv
module phase_sampler
  import frz_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phi2,
  input  logic rw_n,
  input  logic ba,
  output logic evt_any,
  output logic evt_fall,
  output logic evt_rise,
  output logic ended_rd,
  output logic ended_ba
);

  localparam int DEPTH = SYNC + 1;

  bus_smp_t stg [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stg
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stg[0] <= '1;
          else        stg[0] <= '{phi: phi2, rd: rw_n, ba: ba};
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stg[i] <= '1;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  // The last stage holds the final sample of the half-cycle that just ended.
  assign evt_any  = stg[SYNC-1].phi ^ stg[SYNC].phi;
  assign evt_fall = evt_any &  stg[SYNC].phi;
  assign evt_rise = evt_any & ~stg[SYNC].phi;
  assign ended_rd = stg[SYNC].rd;
  assign ended_ba = stg[SYNC].ba;

  AST_EVT_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    evt_any |=> !evt_any); // R7

endmodule

// File: rtl/write_streak.sv
module write_streak
  import frz_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fast_mode,
  input  logic evt_any,
  input  logic evt_fall,
  input  logic evt_rise,
  input  logic ended_rd,
  output logic streak_hit
);

  logic [1:0] cnt;
  logic       count_evt;

  // Normal mode: only CPU halves (closed by a falling edge) count.
  assign count_evt  = fast_mode ? evt_any : evt_fall;
  assign streak_hit = count_evt & ~ended_rd & (cnt >= 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= 2'd0;
    else if (count_evt) cnt <= streak_next(cnt, ~ended_rd);
  end

  AST_SLOW_VIDEO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_mode && evt_rise) |=> $stable(cnt)); // R4

  AST_HIT_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    streak_hit |=> (cnt == 2'd3)); // R5

endmodule

// File: rtl/cycle_timer.sv
module cycle_timer
  import frz_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         expired
);

  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt;

  assign expired = tick && limit_reached(32'(cnt) + 32'd1, 32'(limit));

  always_ff @(posedge clk) begin
    if (!rst_n || clr)              cnt <= '0;
    else if (tick && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  AST_TMR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !tick) |=> $stable(cnt)); // R3

endmodule

// File: rtl/freeze_ctrl.sv
module freeze_ctrl
  import frz_pkg::*;
#(
  parameter int TMR_W = 16,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phi2,
  input  logic             ba,
  input  logic             rw_n,
  input  logic             freeze_req,
  input  logic             fast_mode,
  input  logic [TMR_W-1:0] tmo_badline,
  input  logic [TMR_W-1:0] tmo_writes,
  output logic             dma_req,
  output logic             frozen,
  output logic [1:0]       method
);

  // Named internal events
  logic evt_any, evt_fall, evt_rise, ended_rd, ended_ba;
  logic streak_hit, tmo_exp, tmr_clr, force_slot;
  logic [TMR_W-1:0] tmo_sel;

  frz_state_t  state, nstate;
  frz_method_t meth_q, meth_n;
  logic        dma_n, idle_q, idle_n;

  phase_sampler #(.SYNC(SYNC)) u_smp (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .rw_n(rw_n), .ba(ba),
    .evt_any(evt_any), .evt_fall(evt_fall), .evt_rise(evt_rise),
    .ended_rd(ended_rd), .ended_ba(ended_ba)
  );

  write_streak u_wr (
    .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode),
    .evt_any(evt_any), .evt_fall(evt_fall), .evt_rise(evt_rise),
    .ended_rd(ended_rd), .streak_hit(streak_hit)
  );

  assign tmo_sel = (state == S_WAIT_BAD) ? tmo_badline : tmo_writes;

  cycle_timer #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(evt_fall),
    .limit(tmo_sel), .expired(tmo_exp)
  );

  // A forced stall may only land where no read is cut.
  assign force_slot = fast_mode ? evt_any : evt_fall;

  always_comb begin
    nstate  = state;
    dma_n   = dma_req;
    meth_n  = meth_q;
    idle_n  = idle_q;
    tmr_clr = 1'b0;
    unique case (state)
      S_IDLE: begin
        tmr_clr = 1'b1;
        if (freeze_req) begin
          nstate = S_WAIT_BAD;
          meth_n = M_NONE;
        end
      end
      S_WAIT_BAD: begin
        if (!freeze_req) nstate = S_IDLE;
        else if (evt_any && !ended_ba) begin
          nstate = S_HOLD_BAD;
          dma_n  = 1'b1;
        end else if (tmo_exp) begin
          nstate  = S_WAIT_WR;
          tmr_clr = 1'b1;
        end
      end
      S_HOLD_BAD: begin
        if (!freeze_req) begin
          if (evt_any) begin
            nstate = S_IDLE;
            dma_n  = 1'b0;
          end
        end else if (evt_any && ended_ba) begin
          nstate = S_SETTLE;
          meth_n = M_BADLINE;
          idle_n = 1'b0;
        end
      end
      S_WAIT_WR: begin
        if (!freeze_req) nstate = S_IDLE;
        else if (streak_hit) begin
          nstate = S_SETTLE;
          dma_n  = 1'b1;
          meth_n = M_STREAK;
          idle_n = 1'b0;
        end else if (tmo_exp) begin
          nstate = S_FORCE;
        end
      end
      S_FORCE: begin
        if (!freeze_req) nstate = S_IDLE;
        else if (force_slot) begin
          nstate = S_SETTLE;
          dma_n  = 1'b1;
          meth_n = M_FORCED;
          idle_n = 1'b0;
        end
      end
      S_SETTLE, S_FROZEN: begin
        if (!freeze_req) begin
          if (evt_any) begin
            nstate = S_IDLE;
            dma_n  = 1'b0;
          end
        end else if (state == S_SETTLE && evt_any) begin
          if (!ended_rd)   idle_n = 1'b0;
          else if (idle_q) nstate = S_FROZEN;
          else             idle_n = 1'b1;
        end
      end
      default: begin
        nstate = S_IDLE;
        dma_n  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      dma_req <= 1'b0;
      meth_q  <= M_NONE;
      idle_q  <= 1'b0;
    end else begin
      state   <= nstate;
      dma_req <= dma_n;
      meth_q  <= meth_n;
      idle_q  <= idle_n;
    end
  end

  assign frozen = (state == S_FROZEN);
  assign method = meth_q;

  AST_DMA_RISE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req) |-> $past(evt_any)); // R7

  AST_DMA_FALL_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_req) |-> $past(evt_any)); // R9

  AST_FROZEN_HAS_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> dma_req); // R8

  AST_HOLD_BAD_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HOLD_BAD) |-> dma_req); // R2

  AST_SLOW_FORCE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dma_req) && method == M_FORCED && !fast_mode) |-> $past(evt_fall)); // R6

  AST_METHOD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && $past(frozen)) |-> $stable(method)); // R10

endmodule

// File: tb/tb_freeze_ctrl.sv
module tb_freeze_ctrl;

  localparam int TMR_W = 16;
  localparam int H     = 6;   // clk cycles per half-cycle

  logic clk = 1'b0;
  logic rst_n;
  logic phi2, ba, rw_n, freeze_req, fast_mode;
  logic [TMR_W-1:0] tmo_badline, tmo_writes;
  logic dma_req, frozen;
  logic [1:0] method;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;
  logic cur_phi;

  always #2.5 clk = ~clk;

  freeze_ctrl #(.TMR_W(TMR_W), .SYNC(2)) dut (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .ba(ba), .rw_n(rw_n),
    .freeze_req(freeze_req), .fast_mode(fast_mode),
    .tmo_badline(tmo_badline), .tmo_writes(tmo_writes),
    .dma_req(dma_req), .frozen(frozen), .method(method)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One half-cycle; outputs afterwards reflect the boundary that closed the previous half.
  task automatic half(input logic p, input logic w, input logic b);
    @(negedge clk);
    phi2 = p; rw_n = w; ba = b; cur_phi = p;
    repeat (H - 1) @(negedge clk);
  endtask

  task automatic request();
    if (cur_phi == 1'b0) half(1'b1, 1'b1, 1'b1);
    freeze_req = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 method cleared on request", int'(method), 0);
  endtask

  task automatic release_chk();
    logic prev;
    prev = dma_req;
    freeze_req = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 dma unchanged mid-half", int'(dma_req), int'(prev));
    half(~cur_phi, 1'b1, 1'b1);
    chk("R9 dma dropped at boundary", int'(dma_req), 0);
    chk("R9 frozen dropped", int'(frozen), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; phi2 = 1'b1; ba = 1'b1; rw_n = 1'b1; cur_phi = 1'b1;
    freeze_req = 1'b0; fast_mode = 1'b0; tmo_badline = '0; tmo_writes = '0;
    repeat (5) @(negedge clk);
    chk("R1 dma in reset", int'(dma_req), 0);
    chk("R1 frozen in reset", int'(frozen), 0);
    chk("R1 method in reset", int'(method), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 dma after reset", int'(dma_req), 0);

    // Sweep: forced fallback timing, both modes, small timeouts (R3, R6, R8, R11)
    for (int fm = 0; fm < 2; fm++) begin
      for (int tb = 0; tb < 5; tb++) begin
        for (int tw = 0; tw < 4; tw++) begin
          int tbe, twe, exp_dma, first_dma, first_frz;
          fast_mode   = fm[0];
          tmo_badline = TMR_W'(tb);
          tmo_writes  = TMR_W'(tw);
          request();
          tbe = (tb == 0) ? 1 : tb;
          twe = (tw == 0) ? 1 : tw;
          exp_dma = (fm == 1) ? 2 * (tbe + twe) : 2 * (tbe + twe) + 1;
          first_dma = 0; first_frz = 0;
          for (int h = 1; h <= exp_dma + 4; h++) begin
            half((h % 2) == 0, 1'b1, 1'b1);
            if (dma_req && first_dma == 0) first_dma = h;
            if (frozen && first_frz == 0) first_frz = h;
          end
          chk("R6 R3 R11 forced dma half-cycle", first_dma, exp_dma);
          chk("R8 frozen one cycle after dma", first_frz, exp_dma + 2);
          chk("R6 method forced", int'(method), 3);
          release_chk();
        end
      end
    end

    // Bad line strategy (R2)
    fast_mode = 1'b0; tmo_badline = 16'd20; tmo_writes = 16'd20;
    request();
    half(1'b0, 1'b1, 1'b1); half(1'b1, 1'b1, 1'b1);
    half(1'b0, 1'b1, 1'b0);
    chk("R2 R7 no dma mid bad-line half", int'(dma_req), 0);
    half(1'b1, 1'b1, 1'b0);
    chk("R2 dma on bad line", int'(dma_req), 1);
    for (int k = 0; k < 4; k++) begin
      half(~cur_phi, 1'b1, 1'b0);
      chk("R2 held while ba low", int'(dma_req), 1);
      chk("R2 not frozen while ba low", int'(frozen), 0);
    end
    half(~cur_phi, 1'b1, 1'b1);
    chk("R2 still held", int'(frozen), 0);
    half(~cur_phi, 1'b1, 1'b1);
    chk("R2 method bad line", int'(method), 1);
    chk("R8 not yet frozen", int'(frozen), 0);
    half(~cur_phi, 1'b1, 1'b1);
    chk("R8 not yet frozen 2", int'(frozen), 0);
    half(~cur_phi, 1'b1, 1'b1);
    chk("R8 frozen after idle cycle", int'(frozen), 1);
    release_chk();
    chk("R10 method held after release", int'(method), 1);

    // Normal-mode write streak (R4)
    fast_mode = 1'b0; tmo_badline = 16'd2; tmo_writes = 16'd20;
    request();
    half(1'b0, 1'b1, 1'b1); half(1'b1, 1'b1, 1'b1);
    half(1'b0, 1'b1, 1'b1);          // bad-line wait expires here
    half(1'b1, 1'b0, 1'b1);          // near miss: CPU, video, video writes
    half(1'b0, 1'b0, 1'b1);
    half(1'b1, 1'b1, 1'b1);
    half(1'b0, 1'b0, 1'b1);
    half(1'b1, 1'b1, 1'b1);
    chk("R4 video writes ignored", int'(dma_req), 0);
    half(1'b0, 1'b1, 1'b1);
    chk("R4 video writes ignored 2", int'(dma_req), 0);
    for (int k = 0; k < 3; k++) begin
      half(1'b1, 1'b0, 1'b1);
      chk("R4 no dma before third write closes", int'(dma_req), 0);
      half(1'b0, 1'b1, 1'b1);
    end
    chk("R4 dma after three CPU writes", int'(dma_req), 1);
    chk("R4 method streak", int'(method), 2);
    half(1'b1, 1'b1, 1'b1);
    half(1'b0, 1'b1, 1'b1);
    chk("R8 frozen after streak", int'(frozen), 1);
    release_chk();

    // Fast-mode write streak (R5)
    fast_mode = 1'b1; tmo_badline = 16'd1; tmo_writes = 16'd20;
    request();
    half(1'b0, 1'b1, 1'b1);
    half(1'b1, 1'b0, 1'b1); half(1'b0, 1'b0, 1'b1); half(1'b1, 1'b1, 1'b1);
    half(1'b0, 1'b0, 1'b1); half(1'b1, 1'b0, 1'b1); half(1'b0, 1'b1, 1'b1);
    chk("R5 broken streaks ignored", int'(dma_req), 0);
    half(1'b1, 1'b0, 1'b1); half(1'b0, 1'b0, 1'b1); half(1'b1, 1'b0, 1'b1);
    chk("R5 no dma before third half closes", int'(dma_req), 0);
    half(1'b0, 1'b1, 1'b1);
    chk("R5 dma after three half-cycle writes", int'(dma_req), 1);
    chk("R5 method streak", int'(method), 2);
    release_chk();
    chk("R10 method held after release 2", int'(method), 2);

    // Release while still waiting (R9)
    fast_mode = 1'b0; tmo_badline = 16'd1; tmo_writes = 16'd1;
    request();
    half(1'b0, 1'b1, 1'b1);
    freeze_req = 1'b0;
    for (int k = 0; k < 8; k++) half(~cur_phi, 1'b1, 1'b1);
    chk("R9 no dma after early release", int'(dma_req), 0);
    chk("R9 no frozen after early release", int'(frozen), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule